// File: doc/BRIEF.md
# Programmable Parallel Port Interface

The block is a host-programmable peripheral with three 8-bit I/O ports, called A, B and C. A processor reaches it through a small register bus with a select, a read strobe, a write strobe and a 2-bit address. Through this bus it reads and writes the three ports, loads a control word, and sets or clears single bits of port C. Each pad is modelled as three separate signals: an input, a driven value and a per-bit output enable.

The control word arranges the ports into two groups. Group A holds port A and the upper nibble of C. Group B holds port B and the lower nibble of C. Each group runs in one of two modes:
- **Plain mode.** Every port or nibble is a simple input or output. Outputs are latched. Inputs are read live from the pins.
- **Strobed mode.** Port A or B trades bytes with an external device. The port uses three port C pins as a strobe or acknowledge input, a buffer-full flag and an interrupt request. Port data is latched in both directions.

Every bus access completes in the cycle it is presented. The bus has no ready signal and no back-pressure. A read returns data combinationally in the same cycle. A write takes effect at the next rising clock edge. The external handshake pins are sampled synchronously on each rising edge.

Top module: `pport`

## Requirements
- R1: After reset, every port is an input in plain mode: all output enables are 0, all output latches are 0, and reading address 3 returns 8'h9B.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects control. A control write with bit 7 = 1 is a mode word. In a mode word, bits 6:5 set the group A mode (any nonzero value is strobed), bit 2 sets the group B mode (1 = strobed), and bits 4, 3, 1 and 0 set the direction of A, upper C, B and lower C (1 = input). Reading address 3 returns {1, bits 6:0 of the last mode word}.
- R3: In plain mode, an output port drives its write latch with all enables set. An input port has all enables clear, and a read of it returns the pin levels in that same cycle. No interrupt is raised.
- R4: The direction of C bits 7:4 and of C bits 3:0 is set independently. A read of port C returns pin levels for input bits and latch values for output bits.
- R5: Nothing changes unless bus_sel and bus_wr are both high in a cycle. bus_rdata is 0 unless bus_sel and bus_rd are both high.
- R6: A control write with bit 7 = 0 sets port C latch bit number wdata[3:1] to wdata[0] and leaves the other bits unchanged.
- R7: A mode-word write clears the A, B and C output latches and all buffer-full and interrupt flags.
- R8: For a strobed input port, each clock edge with its strobe pin low captures the port pins and sets its buffer-full pin. A later read returns the captured byte even after the pins change.
- R9: For a strobed input port, the interrupt pin goes high after the strobe pin returns high, but only while the port's enable bit is 1. Reading the port clears both buffer-full and the interrupt.
- R10: For a strobed output port, a write drives its active-low buffer-full pin to 0 and clears its interrupt. Acknowledge low returns buffer-full to 1. The interrupt goes high after acknowledge returns high, if enabled.
- R11: The port C pins of a strobed port have fixed roles:
  - Port A uses C3 for its interrupt, C4 for strobe/acknowledge (an input pin) and C5 for buffer-full. C latch bit 4 is its interrupt enable.
  - Port B uses C0 for its interrupt, C2 for strobe/acknowledge (an input pin) and C1 for buffer-full. C latch bit 2 is its interrupt enable.
  - Reading such a pin returns the driven value, or the enable bit for a strobe pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Device select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not read |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A driven value |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B driven value |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin levels, including strobe/acknowledge inputs |
| pc_out | output | 8 | Port C driven value |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The properties assume that the handshake pins and the bus signals are synchronous to clk and hold steady across each rising edge. They also assume the host does not read a strobed input port in the same cycle its strobe is low. The stimulus changes every input on the falling edge. It holds each strobe or acknowledge pulse for a whole cycle and reads a captured byte only after its strobe has returned high. It never raises read and write together.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
package pport_pkg;
  localparam int PW   = 8;
  localparam int HALF = PW / 2;
  localparam int NHS  = 2;

  localparam int A_INT = 3;
  localparam int A_STB = 4;
  localparam int A_BUF = 5;
  localparam int B_INT = 0;
  localparam int B_BUF = 1;
  localparam int B_STB = 2;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RST = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                               b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pport_cfg.sv
`timescale 1ns/1ps
module pport_cfg import pport_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          c_wr,
  input  logic [PW-1:0] wdata,
  output cfg_t          cfg,
  output logic [PW-1:0] c_latch,
  output logic          mode_set
);
  assign mode_set = ctrl_wr & wdata[PW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= CFG_RST;
      c_latch <= '0;
    end else if (mode_set) begin
      cfg     <= cfg_t'(wdata[PW-2:0]);
      c_latch <= '0;
    end else if (ctrl_wr) begin
      c_latch[wdata[3:1]] <= wdata[0];
    end else if (c_wr) begin
      c_latch <= wdata;
    end
  end

  // R6
  bit_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[PW-1]) |=> (c_latch[$past(wdata[3:1])] == $past(wdata[0])));

  // R7
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (c_latch == '0 && cfg == cfg_t'($past(wdata[PW-2:0]))));

  // R5
  c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr || c_wr) |=> ($stable(c_latch) && $stable(cfg)));
endmodule

// File: rtl/pport_hs.sv
`timescale 1ns/1ps
module pport_hs import pport_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobed,
  input  logic          is_in,
  input  logic          hs_n,
  input  logic [PW-1:0] pin,
  input  logic          rd_evt,
  input  logic          wr_evt,
  input  logic          clr,
  input  logic          inte,
  output logic [PW-1:0] in_data,
  output logic          buf_pin,
  output logic          intr
);
  logic ibf, obf_n, flag, hs_prev;
  logic hs_rise;

  assign hs_rise = !hs_prev && hs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data <= '0;
      ibf     <= 1'b0;
      obf_n   <= 1'b1;
      flag    <= 1'b0;
      hs_prev <= 1'b1;
    end else begin
      hs_prev <= hs_n;
      if (clr) begin
        ibf   <= 1'b0;
        obf_n <= 1'b1;
        flag  <= 1'b0;
      end else if (strobed && is_in) begin
        if (!hs_n) begin
          in_data <= pin;
          ibf     <= 1'b1;
        end else if (rd_evt) begin
          ibf  <= 1'b0;
          flag <= 1'b0;
        end else if (hs_rise && ibf) begin
          flag <= 1'b1;
        end
      end else if (strobed) begin
        if (wr_evt) begin
          obf_n <= 1'b0;
          flag  <= 1'b0;
        end else if (!hs_n) begin
          obf_n <= 1'b1;
        end else if (hs_rise) begin
          flag <= 1'b1;
        end
      end
    end
  end

  assign buf_pin = is_in ? ibf : obf_n;
  assign intr    = flag & inte;

  // R8
  in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobed && is_in && !hs_n && !clr) |=> (ibf && in_data == $past(pin)));

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobed && is_in && hs_n && rd_evt && !clr) |=> (!ibf && !intr));

  // R10
  obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobed && !is_in && wr_evt && !clr) |=> (!obf_n && !flag));

  // R10
  obf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobed && !is_in && !hs_n && !wr_evt && !clr) |=> obf_n);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ibf && obf_n && !flag));

  // R3
  plain_no_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobed |-> !flag);
endmodule

// File: rtl/pport.sv
`timescale 1ns/1ps
module pport import pport_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [PW-1:0] bus_wdata,
  output logic [PW-1:0] bus_rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam logic [1:0] AD_A = 2'd0;
  localparam logic [1:0] AD_B = 2'd1;
  localparam logic [1:0] AD_C = 2'd2;
  localparam logic [1:0] AD_CTL = 2'd3;

  logic acc_wr, acc_rd, mode_set;
  cfg_t cfg;
  logic [PW-1:0] c_latch, la, lb, a_rd, b_rd, c_rd, dir_mask;

  assign acc_wr = bus_sel & bus_wr;
  assign acc_rd = bus_sel & bus_rd;

  pport_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (acc_wr && bus_addr == AD_CTL),
    .c_wr     (acc_wr && bus_addr == AD_C),
    .wdata    (bus_wdata),
    .cfg      (cfg),
    .c_latch  (c_latch),
    .mode_set (mode_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la <= '0;
      lb <= '0;
    end else if (mode_set) begin
      la <= '0;
      lb <= '0;
    end else if (acc_wr && bus_addr == AD_A) begin
      la <= bus_wdata;
    end else if (acc_wr && bus_addr == AD_B) begin
      lb <= bus_wdata;
    end
  end

  logic [NHS-1:0] hs_str, hs_in, hs_pin_n, hs_rd, hs_wr, hs_inte, hs_buf, hs_intr;
  logic [PW-1:0]  hs_port [NHS];
  logic [PW-1:0]  hs_data [NHS];

  assign hs_str   = {cfg.b_mode, |cfg.a_mode};
  assign hs_in    = {cfg.b_in, cfg.a_in};
  assign hs_pin_n = {pc_in[B_STB], pc_in[A_STB]};
  assign hs_rd    = {acc_rd && bus_addr == AD_B, acc_rd && bus_addr == AD_A};
  assign hs_wr    = {acc_wr && bus_addr == AD_B, acc_wr && bus_addr == AD_A};
  assign hs_inte  = {c_latch[B_STB], c_latch[A_STB]};
  assign hs_port[0] = pa_in;
  assign hs_port[1] = pb_in;

  generate
    for (genvar g = 0; g < NHS; g++) begin : g_hs
      pport_hs u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobed (hs_str[g]),
        .is_in   (hs_in[g]),
        .hs_n    (hs_pin_n[g]),
        .pin     (hs_port[g]),
        .rd_evt  (hs_rd[g]),
        .wr_evt  (hs_wr[g]),
        .clr     (mode_set),
        .inte    (hs_inte[g]),
        .in_data (hs_data[g]),
        .buf_pin (hs_buf[g]),
        .intr    (hs_intr[g])
      );
    end
  endgenerate

  assign pa_out = la;
  assign pa_oe  = {PW{!cfg.a_in}};
  assign pb_out = lb;
  assign pb_oe  = {PW{!cfg.b_in}};

  assign dir_mask = {{HALF{cfg.cu_in}}, {HALF{cfg.cl_in}}};

  always_comb begin
    pc_out = c_latch;
    pc_oe  = ~dir_mask;
    c_rd   = (pc_in & dir_mask) | (c_latch & ~dir_mask);
    if (hs_str[1]) begin
      pc_out[B_INT] = hs_intr[1];
      pc_out[B_BUF] = hs_buf[1];
      pc_oe[B_INT]  = 1'b1;
      pc_oe[B_BUF]  = 1'b1;
      pc_oe[B_STB]  = 1'b0;
      c_rd[B_INT]   = hs_intr[1];
      c_rd[B_BUF]   = hs_buf[1];
      c_rd[B_STB]   = c_latch[B_STB];
    end
    if (hs_str[0]) begin
      pc_out[A_INT] = hs_intr[0];
      pc_out[A_BUF] = hs_buf[0];
      pc_oe[A_INT]  = 1'b1;
      pc_oe[A_BUF]  = 1'b1;
      pc_oe[A_STB]  = 1'b0;
      c_rd[A_INT]   = hs_intr[0];
      c_rd[A_BUF]   = hs_buf[0];
      c_rd[A_STB]   = c_latch[A_STB];
    end
  end

  assign a_rd = (hs_str[0] && cfg.a_in) ? hs_data[0] : (cfg.a_in ? pa_in : la);
  assign b_rd = (hs_str[1] && cfg.b_in) ? hs_data[1] : (cfg.b_in ? pb_in : lb);

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      case (bus_addr)
        AD_A:    bus_rdata = a_rd;
        AD_B:    bus_rdata = b_rd;
        AD_C:    bus_rdata = c_rd;
        default: bus_rdata = {1'b1, cfg};
      endcase
    end
  end

  // R7
  port_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (pa_out == '0 && pb_out == '0));

  // R5
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe)));

  // R11
  a_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_mode != 2'b00) |-> (pc_oe[A_INT] && pc_oe[A_BUF] && !pc_oe[A_STB]));

  // R11
  b_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.b_mode |-> (pc_oe[B_INT] && pc_oe[B_BUF] && !pc_oe[B_STB]));

  // R2
  ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && bus_addr == AD_CTL) |-> bus_rdata[PW-1]);

  // R5
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |-> (bus_rdata == '0));
endmodule

// File: tb/pport_tb.sv
`timescale 1ns/1ps
module pport_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h14;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // reference model state
  logic [1:0] m_amode;
  logic m_adir, m_cudir, m_bmode, m_bdir, m_cldir;
  logic [7:0] m_la, m_lb, m_lc;
  logic [7:0] m_cap [2];
  logic m_ibf [2], m_obfn [2], m_flag [2], m_prev [2];
  logic h_hs, h_str, h_din, h_rde, h_wre;
  logic [7:0] h_pin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_amode = 2'b00; m_adir = 1; m_cudir = 1; m_bmode = 0; m_bdir = 1; m_cldir = 1;
      m_la = 0; m_lb = 0; m_lc = 0;
      for (int p = 0; p < 2; p++) begin
        m_cap[p] = 0; m_ibf[p] = 0; m_obfn[p] = 1; m_flag[p] = 0; m_prev[p] = 1;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        h_hs  = (p == 0) ? pc_in[4] : pc_in[2];
        h_str = (p == 0) ? (m_amode != 2'b00) : m_bmode;
        h_din = (p == 0) ? m_adir : m_bdir;
        h_pin = (p == 0) ? pa_in : pb_in;
        h_rde = sel && rd && (addr == p);
        h_wre = sel && wr && (addr == p);
        if (h_str && h_din) begin
          if (!h_hs) begin m_cap[p] = h_pin; m_ibf[p] = 1; end
          else if (h_rde) begin m_ibf[p] = 0; m_flag[p] = 0; end
          else if (!m_prev[p] && m_ibf[p]) m_flag[p] = 1;
        end else if (h_str) begin
          if (h_wre) begin m_obfn[p] = 0; m_flag[p] = 0; end
          else if (!h_hs) m_obfn[p] = 1;
          else if (!m_prev[p]) m_flag[p] = 1;
        end
        m_prev[p] = h_hs;
      end
      if (sel && wr) begin
        case (addr)
          2'd0: m_la = wd;
          2'd1: m_lb = wd;
          2'd2: m_lc = wd;
          default:
            if (wd[7]) begin
              m_amode = wd[6:5]; m_adir = wd[4]; m_cudir = wd[3];
              m_bmode = wd[2]; m_bdir = wd[1]; m_cldir = wd[0];
              m_la = 0; m_lb = 0; m_lc = 0;
              for (int p = 0; p < 2; p++) begin
                m_ibf[p] = 0; m_obfn[p] = 1; m_flag[p] = 0;
              end
            end else m_lc[wd[3:1]] = wd[0];
        endcase
      end
    end
  end

  // expected outputs
  logic [7:0] e_pc, e_pcoe, e_crd, e_rd, e_ard, e_brd;
  logic iA, iB, bA, bB;
  always @* begin
    iA = m_flag[0] & m_lc[4];
    iB = m_flag[1] & m_lc[2];
    bA = m_adir ? m_ibf[0] : m_obfn[0];
    bB = m_bdir ? m_ibf[1] : m_obfn[1];
    e_pc = m_lc;
    e_pcoe = {{4{!m_cudir}}, {4{!m_cldir}}};
    for (int i = 0; i < 8; i++)
      e_crd[i] = ((i >= 4) ? m_cudir : m_cldir) ? pc_in[i] : m_lc[i];
    if (m_bmode) begin
      e_pc[0] = iB; e_pc[1] = bB; e_pcoe[0] = 1; e_pcoe[1] = 1; e_pcoe[2] = 0;
      e_crd[0] = iB; e_crd[1] = bB; e_crd[2] = m_lc[2];
    end
    if (m_amode != 2'b00) begin
      e_pc[3] = iA; e_pc[5] = bA; e_pcoe[3] = 1; e_pcoe[5] = 1; e_pcoe[4] = 0;
      e_crd[3] = iA; e_crd[5] = bA; e_crd[4] = m_lc[4];
    end
    e_ard = (m_amode != 2'b00 && m_adir) ? m_cap[0] : (m_adir ? pa_in : m_la);
    e_brd = (m_bmode && m_bdir) ? m_cap[1] : (m_bdir ? pb_in : m_lb);
    e_rd = 8'h00;
    if (sel && rd) begin
      case (addr)
        2'd0: e_rd = e_ard;
        2'd1: e_rd = e_brd;
        2'd2: e_rd = e_crd;
        default: e_rd = {1'b1, m_amode, m_adir, m_cudir, m_bmode, m_bdir, m_cldir};
      endcase
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(pa_out, m_la, "R3 pa_out");
      chk(pa_oe, {8{!m_adir}}, "R3 pa_oe");
      chk(pb_out, m_lb, "R3 pb_out");
      chk(pb_oe, {8{!m_bdir}}, "R3 pb_oe");
      chk(pc_out, e_pc, "R11 pc_out");
      chk(pc_oe, e_pcoe, "R11 pc_oe");
      chk(rdata, e_rd, "R2 rdata");
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wd = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 chk(rdata, exp, tag);
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    settle();
    chk(pa_oe, 8'h00, "R1 pa_oe"); chk(pb_oe, 8'h00, "R1 pb_oe");
    chk(pc_oe, 8'h00, "R1 pc_oe"); chk(pc_out, 8'h00, "R1 pc_out");
    bus_read(2'd3, 8'h9B, "R1 ctrl");

    // R5 unselected write ignored, R3 plain output
    bus_write(2'd3, 8'h80);
    bus_write(2'd0, 8'h3C);
    @(negedge clk); sel = 0; wr = 1; addr = 2'd0; wd = 8'hFF;
    @(negedge clk); wr = 0;
    bus_read(2'd0, 8'h3C, "R5 port A");
    settle();
    chk(pa_oe, 8'hFF, "R3 pa_oe out"); chk(pa_out, 8'h3C, "R3 pa_out");

    // R4 independent C halves
    bus_write(2'd3, 8'h88);
    bus_write(2'd2, 8'hA5);
    @(negedge clk); pc_in = 8'h70; #1;
    chk(pc_oe, 8'h0F, "R4 pc_oe");
    chk(pc_out[3:0], 8'h05, "R4 pc_out low");
    bus_read(2'd2, 8'h75, "R4 read C");
    @(negedge clk); pc_in = 8'h14;

    // R3 unlatched plain input
    bus_write(2'd3, 8'h90);
    @(negedge clk); pa_in = 8'h12;
    bus_read(2'd0, 8'h12, "R3 live in 1");
    @(negedge clk); pa_in = 8'h34;
    bus_read(2'd0, 8'h34, "R3 live in 2");

    // R6 bit set/reset
    bus_write(2'd3, 8'h07);
    settle(); chk(pc_out, 8'h08, "R6 set bit3");
    bus_write(2'd3, 8'h0D);
    settle(); chk(pc_out, 8'h48, "R6 set bit6");
    bus_write(2'd3, 8'h06);
    bus_read(2'd2, 8'h40, "R6 clear bit3");

    // R7 mode word clears latches
    bus_write(2'd1, 8'h99);
    settle(); chk(pb_out, 8'h99, "R7 pre");
    bus_write(2'd3, 8'h90);
    settle(); chk(pb_out, 8'h00, "R7 pb cleared"); chk(pc_out, 8'h00, "R7 pc cleared");

    // R8 / R9 strobed input on A
    bus_write(2'd3, 8'hB0);
    bus_write(2'd3, 8'h09);
    @(negedge clk); pa_in = 8'h5A; pc_in[4] = 0;
    @(negedge clk); pc_in[4] = 1;
    settle(); settle();
    chk({7'd0, pc_out[5]}, 8'h01, "R8 ibf set");
    chk({7'd0, pc_out[3]}, 8'h01, "R9 intr set");
    @(negedge clk); pa_in = 8'h00;
    bus_read(2'd0, 8'h5A, "R8 latched data");
    #1;
    chk({7'd0, pc_out[5]}, 8'h00, "R9 ibf cleared");
    chk({7'd0, pc_out[3]}, 8'h00, "R9 intr cleared");
    bus_write(2'd3, 8'h08);
    @(negedge clk); pc_in[4] = 0;
    @(negedge clk); pc_in[4] = 1;
    settle(); settle();
    chk({7'd0, pc_out[5]}, 8'h01, "R9 ibf no enable");
    chk({7'd0, pc_out[3]}, 8'h00, "R9 intr masked");

    // R10 / R11 strobed output on B
    bus_write(2'd3, 8'h84);
    bus_read(2'd3, 8'h84, "R2 ctrl echo");
    settle(); chk(pc_oe, 8'hFB, "R11 pc_oe strobed B");
    bus_write(2'd3, 8'h05);
    bus_write(2'd1, 8'hC3);
    #1;
    chk(pb_out, 8'hC3, "R10 pb_out");
    chk({7'd0, pc_out[1]}, 8'h00, "R10 obf low");
    @(negedge clk); pc_in[2] = 0;
    @(negedge clk); pc_in[2] = 1; #1;
    chk({7'd0, pc_out[1]}, 8'h01, "R10 obf released");
    settle();
    chk({7'd0, pc_out[0]}, 8'h01, "R10 intr set");
    bus_write(2'd1, 8'h3C);
    #1;
    chk({7'd0, pc_out[0]}, 8'h00, "R10 intr cleared");
    chk({7'd0, pc_out[1]}, 8'h00, "R10 obf low again");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule